// File: doc/BRIEF.md
# Debug-Mode Bus Grant Controller

This block decides when an external master may take over the system address and data bus while the processor is stopped under serial debug control. A request from outside is honoured only if software has turned the feature on and the debug link is in debug mode. The grant is also kept back until the debug traffic reaches a point where it is safe to hand over the bus. The block follows the serial link bit by bit. Every frame has eight data bits and then one separator bit. A separator of 1 closes a debug operation. A separator of 0 means the operation carries on with another byte.

When nothing is being shifted, a synchronized request is granted on the next clock. While a debug operation is open, the request waits until the closing separator. Whenever the bus is granted, the block raises a flag that tells the debug engine to keep off external memory and I/O. The grant state and an error flag can be read on a status port. The error flag records that debug mode was left while the bus was still granted. In that case the grant is held until the requester lets go.

Top module: `dbg_busgrant`

## Requirements
- R1: After reset the enable bit is 0. Writing `cfg_en_i` with `cfg_we_i` high sets it. While it is 0, `bus_ack_o` stays low however long `bus_req_i` is held.
- R2: `bus_req_i` passes through a two-stage synchronizer. With the feature enabled, debug mode high and no operation open, `bus_ack_o` is still low after the second rising edge following the request and is high after the third.
- R3: An operation opens with the first data bit of a frame. It stays open across any frame whose separator is 0. While it is open, `bus_ack_o` stays low.
- R4: The separator is always the ninth bit of a frame, sampled from `link_bit_i` when `link_vld_i` is high. Data bits of value 1 never close an operation. A separator of 1 closes it, and a pending request is granted on the next rising edge.
- R5: `status_o[0]` reads the grant state and `status_o[1]` reads the error flag.
- R6: `ext_block_o` is high exactly while the bus is granted.
- R7: `bus_ack_o` falls on the third rising edge after `bus_req_i` falls.
- R8: While `dbg_mode_i` is low, no new grant is given.
- R9: If `dbg_mode_i` falls while the bus is granted, `bus_ack_o` stays high until the request is released. The error bit `status_o[1]` sets on that edge. It clears only on a configuration write made while the grant is not being held this way.
- R10: Clearing the enable bit while a request is waiting cancels it. No grant is given until the bit is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req_i | input | 1 | External bus request, asynchronous |
| cfg_we_i | input | 1 | Write strobe for the enable bit |
| cfg_en_i | input | 1 | Value written to the enable bit |
| dbg_mode_i | input | 1 | Processor is in debug mode |
| link_vld_i | input | 1 | A serial link bit is present this cycle |
| link_bit_i | input | 1 | Serial link bit value |
| bus_ack_o | output | 1 | Bus acknowledge |
| ext_block_o | output | 1 | Debug engine must avoid external accesses |
| status_o | output | 2 | {error, grant} status bits |

## Verification
If the frame position counter is wrong, the separator is sampled on the wrong bit. A data bit of 1 would then end the operation early, and `bus_ack_o` would rise in the middle of a frame, one edge after that bit. If the operation flag is wrong, the grant comes in the middle of a multi-byte operation, or it never comes after the closing separator. If the grant state is wrong, it shows on `bus_ack_o`, `ext_block_o` and `status_o` together within one edge of the request, the release or a debug-mode change. A missing or stuck error bit shows on `status_o[1]` on the edge where debug mode drops.

// File: rtl/dbg_bg_pkg.sv
package dbg_bg_pkg;
  typedef enum logic [1:0] {
    BG_IDLE  = 2'd0,
    BG_WAIT  = 2'd1,
    BG_GRANT = 2'd2,
    BG_HOLD  = 2'd3
  } bg_state_e;
endpackage

// File: rtl/dbg_bg_sync.sv
module dbg_bg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/dbg_bg_frame.sv
module dbg_bg_frame #(
  parameter int DATA_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dbg,
  input  logic bit_vld,
  input  logic bit_val,
  output logic busy
);
  localparam int CW = $clog2(DATA_BITS + 1);
  localparam logic [CW-1:0] SEP_POS = CW'(DATA_BITS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          op_q, op_d;

  always_comb begin
    cnt_d = cnt_q;
    op_d  = op_q;
    if (!dbg) begin
      cnt_d = '0;
      op_d  = 1'b0;
    end else if (bit_vld) begin
      if (cnt_q == SEP_POS) begin
        cnt_d = '0;
        op_d  = ~bit_val;
      end else begin
        cnt_d = cnt_q + 1'b1;
        op_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      op_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      op_q  <= op_d;
    end
  end

  assign busy = op_q;

  a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= SEP_POS);
  a_r4_sep_one_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg && bit_vld && bit_val && cnt_q == SEP_POS) |=> !busy);
  a_r3_data_bit_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg && bit_vld && cnt_q != SEP_POS) |=> busy);
endmodule

// File: rtl/dbg_bg_fsm.sv
module dbg_bg_fsm
  import dbg_bg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dbg,
  input  logic req_s,
  input  logic busy,
  input  logic cfg_we,
  input  logic cfg_en,
  output logic ack,
  output logic err
);
  bg_state_e st_q, st_d;
  logic      en_q, en_d;
  logic      err_q, err_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      BG_IDLE:  if (dbg && en_q && req_s) st_d = busy ? BG_WAIT : BG_GRANT;
      BG_WAIT:  if (!req_s || !dbg || !en_q) st_d = BG_IDLE;
                else if (!busy)              st_d = BG_GRANT;
      BG_GRANT: if (!req_s)    st_d = BG_IDLE;
                else if (!dbg) st_d = BG_HOLD;
      BG_HOLD:  if (!req_s)    st_d = BG_IDLE;
      default:  st_d = BG_IDLE;
    endcase
  end

  always_comb begin
    en_d  = cfg_we ? cfg_en : en_q;
    err_d = err_q;
    if (st_q == BG_GRANT && st_d == BG_HOLD)  err_d = 1'b1;
    else if (cfg_we && st_q != BG_HOLD)       err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BG_IDLE;
      en_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      en_q  <= en_d;
      err_q <= err_d;
    end
  end

  assign ack = (st_q == BG_GRANT) || (st_q == BG_HOLD);
  assign err = err_q;

  a_r1_no_ack_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BG_IDLE && !en_q) |=> !ack);
  a_r3_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && busy) |=> !ack);
  a_r7_release_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !req_s) |=> !ack);
  a_r8_no_grant_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !dbg) |=> !ack);
  a_r9_exit_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BG_GRANT && !dbg && req_s) |=> (ack && err_q));
  a_r9_hold_has_err: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BG_HOLD) |-> err_q);
endmodule

// File: rtl/dbg_busgrant.sv
module dbg_busgrant #(
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_req_i,
  input  logic       cfg_we_i,
  input  logic       cfg_en_i,
  input  logic       dbg_mode_i,
  input  logic       link_vld_i,
  input  logic       link_bit_i,
  output logic       bus_ack_o,
  output logic       ext_block_o,
  output logic [1:0] status_o
);
  logic rst_sn, req_s, busy, ack, err;

  dbg_bg_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sn));

  dbg_bg_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst_n(rst_sn), .d(bus_req_i), .q(req_s));

  dbg_bg_frame #(.DATA_BITS(DATA_BITS)) u_frame (
    .clk(clk), .rst_n(rst_sn), .dbg(dbg_mode_i),
    .bit_vld(link_vld_i), .bit_val(link_bit_i), .busy(busy));

  dbg_bg_fsm u_fsm (
    .clk(clk), .rst_n(rst_sn), .dbg(dbg_mode_i), .req_s(req_s), .busy(busy),
    .cfg_we(cfg_we_i), .cfg_en(cfg_en_i), .ack(ack), .err(err));

  assign bus_ack_o   = ack;
  assign ext_block_o = ack;
  assign status_o    = {err, ack};

  a_r8_ack_needs_dbg_or_err: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_ack_o && !dbg_mode_i) |=> (!bus_ack_o || status_o[1]));
endmodule

// File: tb/dbg_busgrant_test.sv
module dbg_busgrant_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req = 1'b0, cfg_we = 1'b0, cfg_en = 1'b0, dbg_mode = 1'b0;
  logic link_vld = 1'b0, link_bit = 1'b0;
  logic bus_ack, ext_block;
  logic [1:0] status;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  dbg_busgrant uut (
    .clk(clk), .rst_n(rst_n), .bus_req_i(bus_req), .cfg_we_i(cfg_we),
    .cfg_en_i(cfg_en), .dbg_mode_i(dbg_mode), .link_vld_i(link_vld),
    .link_bit_i(link_bit), .bus_ack_o(bus_ack), .ext_block_o(ext_block),
    .status_o(status));

  task automatic check(string req, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cfg_write(logic v);
    cfg_we = 1'b1; cfg_en = v;
    cycles(1);
    cfg_we = 1'b0;
  endtask

  task automatic send_bit(logic b);
    link_vld = 1'b1; link_bit = b;
    cycles(1);
    link_vld = 1'b0;
  endtask

  task automatic t_reset;
    check("R5 reset ack", bus_ack, 1'b0);
    check("R5 reset err", status[1], 1'b0);
    check("R6 reset block", ext_block, 1'b0);
  endtask

  task automatic t_disabled;
    dbg_mode = 1'b1; bus_req = 1'b1;
    cycles(6);
    check("R1 disabled no ack", bus_ack, 1'b0);
    bus_req = 1'b0; cycles(4);
  endtask

  task automatic t_idle_grant;
    cfg_write(1'b1);
    bus_req = 1'b1;
    cycles(2);
    check("R2 ack low after 2 edges", bus_ack, 1'b0);
    cycles(1);
    check("R2 ack high after 3 edges", bus_ack, 1'b1);
    check("R6 block while granted", ext_block, 1'b1);
    check("R5 status grant bit", status[0], 1'b1);
    bus_req = 1'b0;
    cycles(2);
    check("R7 ack held 2 edges after release", bus_ack, 1'b1);
    cycles(1);
    check("R7 ack low 3 edges after release", bus_ack, 1'b0);
    check("R6 block cleared", ext_block, 1'b0);
    cycles(2);
  endtask

  task automatic t_frame_hold;
    logic bad = 1'b0;
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    bus_req = 1'b1;
    for (int i = 0; i < 5; i++) begin send_bit(1'b1); bad |= bus_ack; end
    send_bit(1'b0);
    check("R4 data ones do not close", bad, 1'b0);
    check("R3 separator 0 keeps open", bus_ack, 1'b0);
    for (int i = 0; i < 8; i++) begin send_bit(1'b1); bad |= bus_ack; end
    check("R3 held through second byte", bad, 1'b0);
    send_bit(1'b1);
    check("R3 not granted on separator edge", bus_ack, 1'b0);
    cycles(1);
    check("R4 granted edge after separator 1", bus_ack, 1'b1);
    bus_req = 1'b0; cycles(5);
  endtask

  task automatic t_outside_dbg;
    dbg_mode = 1'b0; bus_req = 1'b1;
    cycles(6);
    check("R8 no grant outside debug", bus_ack, 1'b0);
    bus_req = 1'b0; cycles(4);
    dbg_mode = 1'b1;
  endtask

  task automatic t_exit_granted;
    bus_req = 1'b1; cycles(4);
    check("R9 granted before exit", bus_ack, 1'b1);
    dbg_mode = 1'b0; cycles(1);
    check("R9 ack held after exit", bus_ack, 1'b1);
    check("R9 err set", status[1], 1'b1);
    cfg_write(1'b1);
    check("R9 err kept during hold", status[1], 1'b1);
    bus_req = 1'b0; cycles(3);
    check("R9 ack drops on release", bus_ack, 1'b0);
    check("R9 err sticky", status[1], 1'b1);
    dbg_mode = 1'b1;
    cfg_write(1'b1);
    check("R9 err cleared by write", status[1], 1'b0);
    cycles(2);
  endtask

  task automatic t_cancel;
    send_bit(1'b0);
    bus_req = 1'b1; cycles(4);
    cfg_write(1'b0);
    for (int i = 0; i < 7; i++) send_bit(1'b0);
    send_bit(1'b1);
    cycles(4);
    check("R10 cancelled after disable", bus_ack, 1'b0);
    cfg_write(1'b1);
    cycles(2);
    check("R10 grant after re-enable", bus_ack, 1'b1);
    bus_req = 1'b0; cycles(4);
  endtask

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(4);
    t_reset();
    t_disabled();
    t_idle_grant();
    t_frame_hold();
    t_outside_dbg();
    t_exit_granted();
    t_cancel();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    cycles(20000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule